// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is a purely combinational integer ALU for a datapath lane. It takes two operands and a 4-bit mode code. It returns a result word and three flags: carry, overflow and zero. One shared adder serves every arithmetic mode. For subtraction, the second operand is inverted and a carry of one is injected at bit 0. The two compare modes reuse that same difference instead of using a separate comparator.

The adder is built from fixed-width lookahead groups. Each group works out its carry-out from generate and propagate terms, while the bits inside a group ripple from the group's carry-in. Overflow is only a flag: the block never traps. The unsigned add and subtract modes hold that flag low.

Top module: `int_alu`

## Requirements
- R1: Mode code 0 (add) and code 1 (unsigned add) give result = A + B modulo 2^32, and carry_out is the carry leaving bit 31.
- R2: Mode code 2 (subtract) and code 3 (unsigned subtract) give result = A + ~B + 1 modulo 2^32, and carry_out is the carry leaving bit 31, which is 1 when no borrow occurs.
- R3: In modes 0 and 2, overflow equals the carry into bit 31 XOR the carry out of bit 31. It is therefore 1 exactly when the signed result does not fit.
- R4: In modes 1 and 3, overflow is always 0, whatever the operands.
- R5: Mode 4 gives A AND B, mode 5 gives A OR B, mode 6 gives A XOR B and mode 7 gives NOT (A OR B). In these four modes, carry_out and overflow are 0.
- R6: In the compare modes 10 and 11, result bits 31 down to 1 are 0, overflow is 0, and carry_out is the carry out of A + ~B + 1.
- R7: In mode 10, result bit 0 is 1 exactly when A < B as signed two's complement values, including at the most positive and most negative operands.
- R8: In mode 11, result bit 0 is 1 exactly when A < B as unsigned values, which is the inverse of the subtract carry-out.
- R9: In every mode, zero is 1 exactly when all 32 result bits are 0.
- R10: Mode codes 8, 9 and 12 to 15 give a result of 0 with carry_out and overflow 0. zero then reads 1, following R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend for subtract and compare) |
| op_b | input | 32 | Second operand |
| mode | input | 4 | Operation select code |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Adder carry out of bit 31 in arithmetic and compare modes, else 0 |
| overflow | output | 1 | Signed overflow for modes 0 and 2, else 0 |
| zero | output | 1 | High when result is all zeros |

## Verification
Carry, overflow and zero can all assert for the same operation, and carry can disagree with overflow in either direction. The bench provokes the coincidence with operand pairs such as 0x80000000 + 0x80000000 in signed and unsigned add. Those pairs wrap to zero and leave a carry, but overflow must be set only in the signed mode. A signed compare at the extreme operands must also return the correct order while the difference's sign bit is wrong. Each flag is judged separately against a value the bench works out arithmetically from the operands.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_ADD  = 4'd0,
        MD_ADDU = 4'd1,
        MD_SUB  = 4'd2,
        MD_SUBU = 4'd3,
        MD_AND  = 4'd4,
        MD_OR   = 4'd5,
        MD_XOR  = 4'd6,
        MD_NOR  = 4'd7,
        MD_SLT  = 4'd10,
        MD_SLTU = 4'd11
    } alu_mode_e;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_CMP   = 2'd2,
        UNIT_NONE  = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_op_e;

    typedef struct packed {
        unit_e     unit;
        logic      sub;   // invert B, carry-in of one
        logic      sgn;   // signed interpretation
        logic_op_e lop;
    } alu_ctrl_t;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
    } alu_flags_t;

    function automatic alu_ctrl_t decode_mode(input logic [MODE_W-1:0] m);
        alu_ctrl_t c;
        c.unit = UNIT_NONE;
        c.sub  = 1'b0;
        c.sgn  = 1'b0;
        c.lop  = LG_AND;
        case (alu_mode_e'(m))
            MD_ADD:  begin c.unit = UNIT_ARITH; c.sgn = 1'b1; end
            MD_ADDU: begin c.unit = UNIT_ARITH; end
            MD_SUB:  begin c.unit = UNIT_ARITH; c.sub = 1'b1; c.sgn = 1'b1; end
            MD_SUBU: begin c.unit = UNIT_ARITH; c.sub = 1'b1; end
            MD_AND:  begin c.unit = UNIT_LOGIC; c.lop = LG_AND; end
            MD_OR:   begin c.unit = UNIT_LOGIC; c.lop = LG_OR;  end
            MD_XOR:  begin c.unit = UNIT_LOGIC; c.lop = LG_XOR; end
            MD_NOR:  begin c.unit = UNIT_LOGIC; c.lop = LG_NOR; end
            MD_SLT:  begin c.unit = UNIT_CMP; c.sub = 1'b1; c.sgn = 1'b1; end
            MD_SLTU: begin c.unit = UNIT_CMP; c.sub = 1'b1; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ialu_adder.sv
module ialu_adder #(
    parameter int W  = 32,
    parameter int GW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry_in_msb,
    output logic         carry_out
);
    localparam int NG = W / GW;

    logic [W-1:0]  bx;
    logic [NG:0]   gcarry;
    logic [W-1:0]  cin_bit;

    assign bx        = sub ? ~b : b;
    assign gcarry[0] = sub;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        logic [GW:0]   lc;
        logic [GW-1:0] gg;
        logic [GW-1:0] pp;
        logic          grp_g;
        logic          grp_p;

        assign lc[0] = gcarry[gi];

        for (genvar bi = 0; bi < GW; bi++) begin : g_bit
            localparam int K = gi * GW + bi;
            assign gg[bi]     = a[K] & bx[K];
            assign pp[bi]     = a[K] ^ bx[K];
            assign lc[bi+1]   = gg[bi] | (pp[bi] & lc[bi]);
            assign sum[K]     = pp[bi] ^ lc[bi];
            assign cin_bit[K] = lc[bi];
        end

        // group generate / propagate for the lookahead chain
        always_comb begin
            grp_g = 1'b0;
            grp_p = 1'b1;
            for (int j = 0; j < GW; j++) begin
                grp_g = gg[j] | (pp[j] & grp_g);
                grp_p = grp_p & pp[j];
            end
        end

        assign gcarry[gi+1] = grp_g | (grp_p & gcarry[gi]);

        // lookahead carry must match the in-group ripple
        always_comb begin
            AST_GROUP_CARRY: assert (lc[GW] == gcarry[gi+1]); // R2
        end
    end

    assign carry_out    = gcarry[NG];
    assign carry_in_msb = cin_bit[W-1];

endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
    import ialu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_op_e    lop,
    output logic [W-1:0] y
);
    always_comb begin
        case (lop)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/ialu_cmp.sv
module ialu_cmp (
    input  logic diff_msb,
    input  logic ovf_raw,
    input  logic carry,
    input  logic sgn,
    output logic lt
);
    // signed: sign of the difference corrected by overflow
    // unsigned: a borrow means A < B
    assign lt = sgn ? (diff_msb ^ ovf_raw) : ~carry;
endmodule

// File: rtl/int_alu.sv
module int_alu
    import ialu_pkg::*;
#(
    parameter int W       = 32,
    parameter int GROUP_W = 4
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [MODE_W-1:0] mode,
    output logic [W-1:0]      result,
    output logic              carry_out,
    output logic              overflow,
    output logic              zero
);
    alu_ctrl_t  ctrl;
    alu_flags_t flg;
    logic [W-1:0] sum;
    logic [W-1:0] lres;
    logic         c_msb_in;
    logic         c_out;
    logic         ovf_raw;
    logic         lt;

    assign ctrl = decode_mode(mode);

    ialu_adder #(.W(W), .GW(GROUP_W)) u_add (
        .a            (op_a),
        .b            (op_b),
        .sub          (ctrl.sub),
        .sum          (sum),
        .carry_in_msb (c_msb_in),
        .carry_out    (c_out)
    );

    ialu_logic #(.W(W)) u_lg (
        .a   (op_a),
        .b   (op_b),
        .lop (ctrl.lop),
        .y   (lres)
    );

    assign ovf_raw = c_msb_in ^ c_out;

    ialu_cmp u_cmp (
        .diff_msb (sum[W-1]),
        .ovf_raw  (ovf_raw),
        .carry    (c_out),
        .sgn      (ctrl.sgn),
        .lt       (lt)
    );

    always_comb begin
        result    = '0;
        flg.carry = 1'b0;
        flg.ovf   = 1'b0;
        case (ctrl.unit)
            UNIT_ARITH: begin
                result    = sum;
                flg.carry = c_out;
                flg.ovf   = ctrl.sgn & ovf_raw;
            end
            UNIT_LOGIC: result = lres;
            UNIT_CMP: begin
                result    = {{(W-1){1'b0}}, lt};
                flg.carry = c_out;
            end
            default: ;
        endcase
        flg.zero = ~|result;
    end

    assign carry_out = flg.carry;
    assign overflow  = flg.ovf;
    assign zero      = flg.zero;

    // independent reference terms for the checks below
    logic [W-1:0] ref_bx;
    logic [W:0]   ref_sum;
    assign ref_bx  = ctrl.sub ? ~op_b : op_b;
    assign ref_sum = {1'b0, op_a} + {1'b0, ref_bx} + {{W{1'b0}}, ctrl.sub};

    always_comb begin
        if (ctrl.unit == UNIT_ARITH)
            AST_ARITH_SUM: assert ({carry_out, result} == ref_sum); // R1
        if (ctrl.unit == UNIT_ARITH && ctrl.sgn)
            AST_SIGNED_OVF: assert (overflow == ((op_a[W-1] == ref_bx[W-1]) && (result[W-1] != op_a[W-1]))); // R3
        if (ctrl.unit == UNIT_ARITH && !ctrl.sgn)
            AST_NO_OVERFLOW: assert (!overflow); // R4
        if (ctrl.unit == UNIT_LOGIC)
            AST_LOGIC_FLAGS: assert (!carry_out && !overflow); // R5
        if (ctrl.unit == UNIT_CMP)
            AST_CMP_UPPER: assert (result[W-1:1] == '0 && !overflow); // R6
        if (ctrl.unit == UNIT_CMP && ctrl.sgn)
            AST_SLT_ORDER: assert (result[0] == ($signed(op_a) < $signed(op_b))); // R7
        if (ctrl.unit == UNIT_CMP && !ctrl.sgn)
            AST_SLTU_ORDER: assert (result[0] == (op_a < op_b)); // R8
        if (ctrl.unit == UNIT_NONE)
            AST_UNUSED_MODE: assert (result == '0 && !carry_out && !overflow); // R10
    end

endmodule

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [3:0]  mode;
    logic [31:0] result;
    logic        carry_out;
    logic        overflow;
    logic        zero;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    int_alu u_dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .mode      (mode),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow),
        .zero      (zero)
    );

    // expected {result, carry, overflow, zero} from the requirements
    function automatic logic [34:0] expect_of(input logic [31:0] a, input logic [31:0] b,
                                              input logic [3:0] m);
        logic [32:0] s;
        logic [31:0] r;
        logic c;
        logic v;
        r = '0; c = 1'b0; v = 1'b0;
        case (m)
            4'd0, 4'd1: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[31:0]; c = s[32];
                if (m == 4'd0) v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'd2, 4'd3: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = s[31:0]; c = s[32];
                if (m == 4'd2) v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: r = ~(a | b);
            4'd10: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                c = s[32];
                r = {31'd0, ($signed(a) < $signed(b))};
            end
            4'd11: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                c = s[32];
                r = {31'd0, (a < b)};
            end
            default: ;
        endcase
        return {r, c, v, (r == 32'd0)};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [3:0] m);
        logic [34:0] e;
        @(negedge clk);
        op_a = a; op_b = b; mode = m;
        #1;
        e = expect_of(a, b, m);
        chk(req, "result",   result,           e[34:3]);
        chk(req, "carry",    {31'd0, carry_out}, {31'd0, e[2]});
        chk(req, "overflow", {31'd0, overflow},  {31'd0, e[1]});
        chk(req, "zero",     {31'd0, zero},      {31'd0, e[0]});
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        #1;
        chk("R9", "reset result", result, 32'd0);
        chk("R9", "reset zero", {31'd0, zero}, 32'd1);
        chk("R1", "reset carry", {31'd0, carry_out}, 32'd0);
    endtask

    task automatic t_add();
        run_op("R1", 32'd5, 32'd7, 4'd0);
        run_op("R1", 32'hFFFF_FFFF, 32'd1, 4'd1);
        run_op("R3", 32'h7FFF_FFFF, 32'd1, 4'd0);
        run_op("R4", 32'h7FFF_FFFF, 32'd1, 4'd1);
        run_op("R3", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'd0);
    endtask

    task automatic t_sub();
        run_op("R2", 32'd10, 32'd3, 4'd2);
        run_op("R2", 32'd3, 32'd10, 4'd3);
        run_op("R3", 32'h8000_0000, 32'd1, 4'd2);
        run_op("R4", 32'h8000_0000, 32'd1, 4'd3);
        run_op("R9", 32'h1234_5678, 32'h1234_5678, 4'd2);
    endtask

    task automatic t_logic();
        run_op("R5", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd4);
        run_op("R5", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd5);
        run_op("R5", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd6);
        run_op("R5", 32'hF0F0_1234, 32'h0FF0_FF00, 4'd7);
        run_op("R9", 32'hFFFF_FFFF, 32'd0, 4'd7);
        run_op("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd4);
    endtask

    task automatic t_slt();
        run_op("R7", 32'h8000_0000, 32'd1, 4'd10);
        run_op("R7", 32'h7FFF_FFFF, 32'h8000_0000, 4'd10);
        run_op("R7", 32'hFFFF_FFFF, 32'd0, 4'd10);
        run_op("R6", 32'd4, 32'd4, 4'd10);
    endtask

    task automatic t_sltu();
        run_op("R8", 32'h8000_0000, 32'd1, 4'd11);
        run_op("R8", 32'd0, 32'hFFFF_FFFF, 4'd11);
        run_op("R6", 32'd9, 32'd9, 4'd11);
    endtask

    task automatic t_unused();
        for (int k = 8; k < 16; k++) begin
            if (k == 10 || k == 11) continue;
            run_op("R10", 32'hDEAD_BEEF, 32'hFFFF_FFFF, k[3:0]);
        end
    endtask

    task automatic t_coincide();
        run_op("R3", 32'h8000_0000, 32'h8000_0000, 4'd0);
        run_op("R4", 32'h8000_0000, 32'h8000_0000, 4'd1);
        run_op("R2", 32'd0, 32'd0, 4'd3);
    endtask

    function automatic string req_of(input logic [3:0] m);
        if (m <= 4'd1) return "R1";
        if (m <= 4'd3) return "R2";
        if (m <= 4'd7) return "R5";
        if (m == 4'd10) return "R7";
        if (m == 4'd11) return "R8";
        return "R10";
    endfunction

    task automatic t_sweep();
        logic [31:0] x = 32'h1357_9BDF;
        logic [31:0] y = 32'h2468_ACE0;
        for (int i = 0; i < 320; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            y = y ^ (y << 7);  y = y ^ (y >> 9);  y = y ^ (y << 11);
            if (i % 16 == 3) y = x;
            run_op(req_of(i[3:0]), x, y, i[3:0]);
        end
    endtask

    initial begin
        op_a = '0; op_b = '0; mode = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_add();
        t_sub();
        t_logic();
        t_slt();
        t_sltu();
        t_unused();
        t_coincide();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule